// File: doc/BRIEF.md
# Trap Status Word Adjustment Unit

This block carries out the status-doubleword exchange that a processor runs when it enters a trap. A start request brings in the word address of the exchange target, the trap vector location, and the trap context. The context has four fault-cause flags, the four-bit register field of the system call that raised the trap, a four-bit saved trap code, and the advance flag of the exchange instruction. The block first writes the status doubleword it currently holds to two consecutive words at the target address. It then reads the doubleword two words further on. It modifies that doubleword according to the trap vector and holds the result as its new status.

The vector decides what the new status words gain. A nonallowed-operation trap adds one condition-code bit for each reported fault cause and can move the resume address forward by a weighted sum of those causes. A system-call trap merges the caller's register field into the condition code and can add it to the resume address. A watchdog, parity or instruction-exception trap does the same with the saved trap code. Any other vector leaves the fetched doubleword untouched. The memory side is a plain word-addressed bus. Writes commit at the clock edge. Read data is returned combinationally in the same cycle.

Top module: `trap_psw_exchange`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `mem_we` and `mem_re` are low and both status words read zero.
- R2: For vector 0x40, each set bit of `fault_flags` sets one condition-code bit of new word 0, and condition-code bits already set in the fetched word stay set. The flag bits map as follows: bit 3 (nonexistent instruction) to word bit 31, bit 2 (nonexistent memory) to bit 30, bit 1 (privileged in slave mode) to bit 29, and bit 0 (protection violation) to bit 28.
- R3: For vector 0x40 with `adv_bit` = 1, the resume address (word-0 bits 16:0) increases by 8, 4, 2 and 1 for flag bits 3, 2, 1 and 0 respectively. This gives 10 for bits 3 and 1 together and 5 for bits 2 and 0 together.
- R4: For vectors 0x48 through 0x4B, `call_rfield` is ORed into word-0 bits 31:28. When `adv_bit` = 1, it is also added to the resume address.
- R5: For vectors 0x46, 0x4C and 0x4D, `trap_cc` is ORed into word-0 bits 31:28. When `adv_bit` = 1, it is also added to the resume address.
- R6: When `adv_bit` = 0, the resume address is kept as fetched. For any vector outside those in R2 to R5, the fetched doubleword is taken unchanged whatever the fault, call, code and advance inputs are.
- R7: The resume-address addition wraps modulo 2^17. Word-0 bits 27:17 and all of word 1 are never altered by the adjustment.
- R8: An exchange drives exactly four bus cycles in this order: write current word 0 at `ea`, write current word 1 at `ea`+1, read `ea`+2 as new word 0, read `ea`+3 as new word 1.
- R9: `busy` is high from the cycle after an accepted start until the exchange ends. The new status is visible when `done` pulses high for one cycle, the cycle after it is loaded. A start request raised while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Exchange request, taken only when idle |
| ea | input | ADDR_W | Word address of the exchange target |
| trap_vec | input | 8 | Trap vector location |
| fault_flags | input | 4 | Nonallowed-operation causes (see R2) |
| call_rfield | input | 4 | Register field of the trapping system call |
| trap_cc | input | 4 | Saved trap condition code |
| adv_bit | input | 1 | Advance flag of the exchange instruction |
| mem_we | output | 1 | Bus write strobe |
| mem_re | output | 1 | Bus read strobe |
| mem_addr | output | ADDR_W | Bus word address |
| mem_wdata | output | 32 | Bus write data |
| mem_rdata | input | 32 | Bus read data, same cycle |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle pulse, new status valid |
| psw_w0 | output | 32 | Status word 0 (bit 31 is condition-code bit 1) |
| psw_w1 | output | 32 | Status word 1 |

## Verification
Two situations are hard to reach from the ports. The first is a start request arriving while an exchange is in flight, because the request has to land on one particular phase. The bench pulses `start` with a different target address at chosen phase offsets, including the final `done` cycle, and expects the bus pattern and status to continue unchanged. The second is a wrap of the resume address, which needs a fetched doubleword whose address field is near all ones with the surrounding reserved bits set. The bench loads exactly such words into the read path. The fetched doublewords also carry condition-code bits that are already set, so the OR behaviour can be told apart from a plain overwrite.

// File: rtl/trap_psw_pkg.sv
package trap_psw_pkg;

  localparam int WORD_W   = 32;
  localparam int CC_W     = 4;
  localparam int IA_W     = 17;
  localparam int VEC_W    = 8;
  localparam int NUM_CALL = 4;
  localparam int NUM_EXC  = 3;

  localparam logic [VEC_W-1:0] VEC_NONALLOWED = 8'h40;
  localparam logic [VEC_W-1:0] VEC_CALL_BASE  = 8'h48;
  // watchdog, parity, instruction exception
  localparam logic [NUM_EXC*VEC_W-1:0] EXC_VECS = {8'h4D, 8'h4C, 8'h46};

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_FAULT,
    SRC_CALL,
    SRC_CODE
  } mod_src_e;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_PUT0,
    XS_PUT1,
    XS_GET0,
    XS_GET1,
    XS_APPLY,
    XS_FIN
  } xchg_st_e;

  typedef struct packed {
    logic [WORD_W-1:0] w0;
    logic [WORD_W-1:0] w1;
  } status_dw_t;

endpackage

// File: rtl/trap_mod_select.sv
module trap_mod_select
  import trap_psw_pkg::*;
(
  input  logic [VEC_W-1:0] vec,
  input  logic [CC_W-1:0]  fault,
  input  logic [CC_W-1:0]  rfield,
  input  logic [CC_W-1:0]  code,
  output logic [CC_W-1:0]  modv,
  output mod_src_e         src
);

  logic [NUM_CALL-1:0] call_hit;
  logic [NUM_EXC-1:0]  exc_hit;
  logic                fault_hit;

  assign fault_hit = (vec == VEC_NONALLOWED);

  generate
    for (genvar i = 0; i < NUM_CALL; i++) begin : g_call
      localparam logic [VEC_W-1:0] CALL_V = VEC_CALL_BASE + VEC_W'(i);
      assign call_hit[i] = (vec == CALL_V);
    end
    for (genvar j = 0; j < NUM_EXC; j++) begin : g_exc
      localparam logic [VEC_W-1:0] EXC_V = EXC_VECS[j*VEC_W +: VEC_W];
      assign exc_hit[j] = (vec == EXC_V);
    end
  endgenerate

  always_comb begin
    src  = SRC_NONE;
    modv = '0;
    if (fault_hit) begin
      src  = SRC_FAULT;
      modv = fault;
    end else if (|call_hit) begin
      src  = SRC_CALL;
      modv = rfield;
    end else if (|exc_hit) begin
      src  = SRC_CODE;
      modv = code;
    end
  end

endmodule

// File: rtl/trap_cc_adjust.sv
module trap_cc_adjust
  import trap_psw_pkg::*;
(
  input  logic [WORD_W-1:0] w_in,
  input  logic [CC_W-1:0]   modv,
  input  logic              hit,
  input  logic              adv,
  output logic [WORD_W-1:0] w_out
);

  localparam int CC_LSB = WORD_W - CC_W;

  logic [IA_W-1:0] ia_sum;

  assign ia_sum = w_in[IA_W-1:0] + IA_W'(modv);

  always_comb begin
    w_out = w_in;
    if (hit) begin
      w_out[WORD_W-1:CC_LSB] = w_in[WORD_W-1:CC_LSB] | modv;
      if (adv) begin
        w_out[IA_W-1:0] = ia_sum;
      end
    end
  end

endmodule

// File: rtl/trap_xchg_fsm.sv
module trap_xchg_fsm
  import trap_psw_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] ea_in,
  input  status_dw_t        cur_psw,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              accept,
  output logic              get0_en,
  output logic              get1_en,
  output logic              apply_en,
  output logic              busy,
  output logic              done
);

  localparam logic [ADDR_W-1:0] OFS_W1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_N0 = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_N1 = ADDR_W'(3);

  xchg_st_e          state_q, state_d;
  logic [ADDR_W-1:0] ea_q;

  assign accept = (state_q == XS_IDLE) && start;

  always_comb begin
    state_d = state_q;
    case (state_q)
      XS_IDLE:  if (start) state_d = XS_PUT0;
      XS_PUT0:  state_d = XS_PUT1;
      XS_PUT1:  state_d = XS_GET0;
      XS_GET0:  state_d = XS_GET1;
      XS_GET1:  state_d = XS_APPLY;
      XS_APPLY: state_d = XS_FIN;
      XS_FIN:   state_d = XS_IDLE;
      default:  state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      ea_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        ea_q <= ea_in;
      end
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = ea_q;
    mem_wdata = '0;
    get0_en   = 1'b0;
    get1_en   = 1'b0;
    apply_en  = 1'b0;
    done      = 1'b0;
    case (state_q)
      XS_PUT0: begin
        mem_we    = 1'b1;
        mem_wdata = cur_psw.w0;
      end
      XS_PUT1: begin
        mem_we    = 1'b1;
        mem_addr  = ea_q + OFS_W1;
        mem_wdata = cur_psw.w1;
      end
      XS_GET0: begin
        mem_re   = 1'b1;
        mem_addr = ea_q + OFS_N0;
        get0_en  = 1'b1;
      end
      XS_GET1: begin
        mem_re   = 1'b1;
        mem_addr = ea_q + OFS_N1;
        get1_en  = 1'b1;
      end
      XS_APPLY: apply_en = 1'b1;
      XS_FIN:   done     = 1'b1;
      default:  ;
    endcase
  end

  assign busy = (state_q != XS_IDLE);

  // R8
  first_write_at_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_we && (mem_addr == ea_q)));

  // R8
  fetch_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (mem_addr == $past(mem_addr) + OFS_W1));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ea_q));

  // R8
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

endmodule

// File: rtl/trap_psw_exchange.sv
module trap_psw_exchange
  import trap_psw_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] ea,
  input  logic [7:0]        trap_vec,
  input  logic [3:0]        fault_flags,
  input  logic [3:0]        call_rfield,
  input  logic [3:0]        trap_cc,
  input  logic              adv_bit,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [31:0]       psw_w0,
  output logic [31:0]       psw_w1
);

  localparam int CC_LSB = WORD_W - CC_W;

  status_dw_t        psw_q;
  logic [VEC_W-1:0]  vec_q;
  logic [CC_W-1:0]   fault_q, rfield_q, code_q;
  logic              adv_q;
  logic [WORD_W-1:0] nw0_q, nw1_q;
  logic [WORD_W-1:0] adj_w0;
  logic [CC_W-1:0]   modv;
  mod_src_e          src;
  logic              accept, get0_en, get1_en, apply_en;

  trap_xchg_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ea_in     (ea),
    .cur_psw   (psw_q),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .accept    (accept),
    .get0_en   (get0_en),
    .get1_en   (get1_en),
    .apply_en  (apply_en),
    .busy      (busy),
    .done      (done)
  );

  trap_mod_select u_sel (
    .vec    (vec_q),
    .fault  (fault_q),
    .rfield (rfield_q),
    .code   (code_q),
    .modv   (modv),
    .src    (src)
  );

  trap_cc_adjust u_adj (
    .w_in  (nw0_q),
    .modv  (modv),
    .hit   (src != SRC_NONE),
    .adv   (adv_q),
    .w_out (adj_w0)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q    <= '0;
      fault_q  <= '0;
      rfield_q <= '0;
      code_q   <= '0;
      adv_q    <= 1'b0;
    end else if (accept) begin
      vec_q    <= trap_vec;
      fault_q  <= fault_flags;
      rfield_q <= call_rfield;
      code_q   <= trap_cc;
      adv_q    <= adv_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nw0_q <= '0;
      nw1_q <= '0;
    end else begin
      if (get0_en) nw0_q <= mem_rdata;
      if (get1_en) nw1_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psw_q <= '0;
    end else if (apply_en) begin
      psw_q <= '{w0: adj_w0, w1: nw1_q};
    end
  end

  assign psw_w0 = psw_q.w0;
  assign psw_w1 = psw_q.w1;

  // R2
  cc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apply_en |=> ((psw_q.w0[WORD_W-1:CC_LSB] & $past(nw0_q[WORD_W-1:CC_LSB]))
                  == $past(nw0_q[WORD_W-1:CC_LSB])));

  // R7
  reserved_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apply_en |=> ((psw_q.w1 == $past(nw1_q)) &&
                  (psw_q.w0[CC_LSB-1:IA_W] == $past(nw0_q[CC_LSB-1:IA_W]))));

  // R6
  no_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_en && !adv_q) |=> (psw_q.w0[IA_W-1:0] == $past(nw0_q[IA_W-1:0])));

  // R9
  psw_change_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psw_q != $past(psw_q)) |-> done);

endmodule

// File: tb/sim_trap_psw_exchange.sv
`timescale 1ns/1ps
module sim_trap_psw_exchange;

  typedef struct packed {
    logic        we;
    logic        re;
    logic [16:0] addr;
    logic [31:0] wdata;
    logic        busy;
    logic        done;
    logic [63:0] psw;
  } exp_t;

  logic        clk, rst_n, start, adv_bit;
  logic [16:0] ea;
  logic [7:0]  trap_vec;
  logic [3:0]  fault_flags, call_rfield, trap_cc;
  logic        mem_we, mem_re, busy, done;
  logic [16:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata, psw_w0, psw_w1;

  logic [16:0] cur_ea;
  logic [31:0] nxt0, nxt1;
  logic [63:0] model_psw;

  exp_t  q[$];
  string tq[$];
  int    compared = 0;
  int    mismatched = 0;
  bit    finished = 0;

  trap_psw_exchange #(.ADDR_W(17)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .trap_vec(trap_vec),
    .fault_flags(fault_flags), .call_rfield(call_rfield), .trap_cc(trap_cc),
    .adv_bit(adv_bit), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .psw_w0(psw_w0), .psw_w1(psw_w1)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // word-array read side: only the two fetch words are populated
  assign mem_rdata = (mem_addr == cur_ea + 17'd2) ? nxt0 :
                     (mem_addr == cur_ea + 17'd3) ? nxt1 : 32'hDEAD_BEEF;

  function automatic logic [31:0] ref_w0(input logic [7:0] v, input logic [3:0] f,
                                         input logic [3:0] r, input logic [3:0] t,
                                         input logic a, input logic [31:0] w);
    int m;
    logic [31:0] o;
    m = -1;
    if (v == 8'h40) m = int'(f);
    else if (v >= 8'h48 && v <= 8'h4B) m = int'(r);
    else if (v == 8'h46 || v == 8'h4C || v == 8'h4D) m = int'(t);
    o = w;
    if (m >= 0) begin
      o[31:28] = w[31:28] | 4'(m);
      if (a) o[16:0] = 17'((int'(w[16:0]) + m) % 131072);
    end
    return o;
  endfunction

  task automatic step();
    exp_t  e;
    string tg;
    bit    bad;
    @(negedge clk);
    if (q.size() > 0) begin
      e  = q.pop_front();
      tg = tq.pop_front();
    end else begin
      e  = '{we: 1'b0, re: 1'b0, addr: '0, wdata: '0, busy: 1'b0, done: 1'b0, psw: model_psw};
      tg = "R9";
    end
    compared++;
    bad = 0;
    if (mem_we !== e.we || mem_re !== e.re) begin
      $display("FAIL R8 strobes: actual we=%0b re=%0b expected we=%0b re=%0b",
               mem_we, mem_re, e.we, e.re);
      bad = 1;
    end
    if ((e.we || e.re) && mem_addr !== e.addr) begin
      $display("FAIL R8 addr: actual %h expected %h", mem_addr, e.addr);
      bad = 1;
    end
    if (e.we && mem_wdata !== e.wdata) begin
      $display("FAIL R8 wdata: actual %h expected %h", mem_wdata, e.wdata);
      bad = 1;
    end
    if (busy !== e.busy || done !== e.done) begin
      $display("FAIL R9 busy/done: actual %0b/%0b expected %0b/%0b", busy, done, e.busy, e.done);
      bad = 1;
    end
    if ({psw_w0, psw_w1} !== e.psw) begin
      $display("FAIL %s psw: actual %h expected %h", tg, {psw_w0, psw_w1}, e.psw);
      bad = 1;
    end
    if (bad) mismatched++;
  endtask

  task automatic push(input string tg, input logic we, input logic re, input logic [16:0] ad,
                      input logic [31:0] wd, input logic dn, input logic [63:0] p);
    q.push_back('{we: we, re: re, addr: ad, wdata: wd, busy: 1'b1, done: dn, psw: p});
    tq.push_back(tg);
  endtask

  // mid: phase (1..6) at which a stray start is raised, 0 for none
  task automatic xchg(input string tg, input logic [7:0] v, input logic [3:0] f,
                      input logic [3:0] r, input logic [3:0] t, input logic a,
                      input logic [16:0] e, input logic [31:0] n0, input logic [31:0] n1,
                      input int mid);
    logic [63:0] newp;
    newp = {ref_w0(v, f, r, t, a, n0), n1};
    cur_ea = e; nxt0 = n0; nxt1 = n1;
    ea = e; trap_vec = v; fault_flags = f; call_rfield = r; trap_cc = t; adv_bit = a;
    start = 1'b1;
    push(tg, 1'b1, 1'b0, e,          model_psw[63:32], 1'b0, model_psw);
    push(tg, 1'b1, 1'b0, e + 17'd1,  model_psw[31:0],  1'b0, model_psw);
    push(tg, 1'b0, 1'b1, e + 17'd2,  32'h0,            1'b0, model_psw);
    push(tg, 1'b0, 1'b1, e + 17'd3,  32'h0,            1'b0, model_psw);
    push(tg, 1'b0, 1'b0, 17'h0,      32'h0,            1'b0, model_psw);
    push(tg, 1'b0, 1'b0, 17'h0,      32'h0,            1'b1, newp);
    model_psw = newp;
    for (int k = 1; k <= 6; k++) begin
      step();
      start = 1'b0;
      // scramble the context so late latching shows up
      trap_vec = 8'h40; fault_flags = ~f; call_rfield = ~r; trap_cc = ~t; adv_bit = ~a;
      if (k == mid) begin
        start = 1'b1;
        ea = e + 17'h0400;
      end
    end
    start = 1'b0;
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL R9 watchdog: actual no end expected end of run");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; ea = '0; trap_vec = '0; fault_flags = '0;
    call_rfield = '0; trap_cc = '0; adv_bit = 1'b0;
    cur_ea = '0; nxt0 = '0; nxt1 = '0; model_psw = '0;
    repeat (3) @(posedge clk);
    // R1: reset state observed while held
    @(negedge clk);
    compared++;
    if (busy !== 1'b0 || done !== 1'b0 || mem_we !== 1'b0 || mem_re !== 1'b0 ||
        {psw_w0, psw_w1} !== 64'h0) begin
      $display("FAIL R1 reset: actual busy=%0b done=%0b psw=%h expected 0 0 0",
               busy, done, {psw_w0, psw_w1});
      mismatched++;
    end
    rst_n = 1'b1;
    step(); step();

    // R2: single causes, no advance; fetched CC bits stay set
    xchg("R2", 8'h40, 4'b1000, 4'h0, 4'h0, 1'b0, 17'h00100, 32'h0000_0100, 32'h1234_5678, 0);
    xchg("R2", 8'h40, 4'b0100, 4'h0, 4'h0, 1'b0, 17'h00200, 32'h1000_0200, 32'hCAFE_0001, 0);
    xchg("R2", 8'h40, 4'b0010, 4'h0, 4'h0, 1'b0, 17'h00300, 32'h8000_0300, 32'h0BAD_F00D, 0);
    xchg("R2", 8'h40, 4'b0001, 4'h0, 4'h0, 1'b0, 17'h1FF00, 32'h2000_0400, 32'h5555_AAAA, 0);
    // R3: weighted advance, single and paired causes
    xchg("R3", 8'h40, 4'b1000, 4'h0, 4'h0, 1'b1, 17'h00400, 32'h0000_1000, 32'h1111_1111, 0);
    xchg("R3", 8'h40, 4'b0100, 4'h0, 4'h0, 1'b1, 17'h00410, 32'h0000_1000, 32'h2222_2222, 0);
    xchg("R3", 8'h40, 4'b0010, 4'h0, 4'h0, 1'b1, 17'h00420, 32'h0000_1000, 32'h3333_3333, 0);
    xchg("R3", 8'h40, 4'b0001, 4'h0, 4'h0, 1'b1, 17'h00430, 32'h0000_1000, 32'h4444_4444, 0);
    xchg("R3", 8'h40, 4'b1010, 4'h0, 4'h0, 1'b1, 17'h00440, 32'h0000_1000, 32'h6666_6666, 0);
    xchg("R3", 8'h40, 4'b0101, 4'h0, 4'h0, 1'b1, 17'h00450, 32'h0000_1000, 32'h7777_7777, 0);
    // R4: system-call vectors
    xchg("R4", 8'h48, 4'h9, 4'h3, 4'h0, 1'b1, 17'h00500, 32'h8000_2000, 32'h0000_0048, 0);
    xchg("R4", 8'h49, 4'h0, 4'h5, 4'h0, 1'b1, 17'h00510, 32'h0000_2000, 32'h0000_0049, 0);
    xchg("R4", 8'h4A, 4'h0, 4'h0, 4'h7, 1'b1, 17'h00520, 32'h4000_2000, 32'h0000_004A, 0);
    xchg("R4", 8'h4B, 4'h0, 4'hF, 4'h0, 1'b0, 17'h00530, 32'h0000_2000, 32'h0000_004B, 0);
    // R5: saved trap code vectors
    xchg("R5", 8'h46, 4'hF, 4'h0, 4'h6, 1'b1, 17'h00600, 32'h0000_3000, 32'h0000_0046, 0);
    xchg("R5", 8'h4C, 4'h0, 4'hF, 4'h9, 1'b0, 17'h00610, 32'h2000_3000, 32'h0000_004C, 0);
    xchg("R5", 8'h4D, 4'h0, 4'h0, 4'hF, 1'b1, 17'h00620, 32'h0000_3000, 32'h0000_004D, 0);
    // R6: vectors without adjustment, advance set and all fields nonzero
    xchg("R6", 8'h44, 4'hF, 4'hF, 4'hF, 1'b1, 17'h00700, 32'h5000_4000, 32'h0000_0044, 0);
    xchg("R6", 8'h4E, 4'hA, 4'h5, 4'h3, 1'b1, 17'h00710, 32'h0000_4000, 32'h0000_004E, 0);
    xchg("R6", 8'h47, 4'h1, 4'h2, 4'h4, 1'b0, 17'h00720, 32'hF000_4001, 32'h0000_0047, 0);
    // R7: address wrap with reserved bits all ones
    xchg("R7", 8'h40, 4'b0001, 4'h0, 4'h0, 1'b1, 17'h00800, 32'h0FFF_FFFF, 32'hFFFF_FFFF, 0);
    xchg("R7", 8'h4B, 4'h0, 4'hF, 4'h0, 1'b1, 17'h00810, 32'h0FFF_FFF5, 32'h8000_0001, 0);
    xchg("R7", 8'h4C, 4'h0, 4'h0, 4'hC, 1'b1, 17'h1FFFC, 32'hAFFF_FFF8, 32'h0000_0000, 0);
    // R8: target near the top of the address space, fetch wraps
    xchg("R8", 8'h40, 4'b1010, 4'h0, 4'h0, 1'b1, 17'h1FFFE, 32'h0000_0010, 32'h0000_1234, 0);
    // R9: stray start at several phases, including the done cycle
    xchg("R9", 8'h40, 4'b0100, 4'h0, 4'h0, 1'b1, 17'h00900, 32'h0000_5000, 32'h9999_0001, 1);
    xchg("R9", 8'h48, 4'h0, 4'h6, 4'h0, 1'b1, 17'h00910, 32'h0000_5000, 32'h9999_0002, 3);
    xchg("R9", 8'h46, 4'h0, 4'h0, 4'h2, 1'b1, 17'h00920, 32'h0000_5000, 32'h9999_0003, 5);
    xchg("R9", 8'h4D, 4'h0, 4'h0, 4'h1, 1'b1, 17'h00930, 32'h0000_5000, 32'h9999_0004, 6);
    // back-to-back exchange right after a done pulse
    xchg("R9", 8'h40, 4'b0010, 4'h0, 4'h0, 1'b0, 17'h00940, 32'h0000_6000, 32'h9999_0005, 0);
    step(); step();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule